// File: doc/BRIEF.md
# Dual-Clock Quartile-Flag FIFO

This block buffers 36-bit words between a write clock and a read clock that may run at unrelated rates or be tied together. It holds 1024 words. A producer writes by holding an active-low write enable low on a rising write clock edge. A consumer reads by holding an active-low read enable low on a rising read clock edge. Each accepted read loads the next word into a registered output. A plain active-low output gate forces that output to zero when it is not enabled.

Fill level is reported on four active-low status outputs:
- a combined empty-or-full flag;
- a flag for the lower and upper quartiles;
- a more-than-half flag;
- a combined fault flag that latches attempts to read while empty or write while full.

Each flag is evaluated in the clock domain whose pointer can change it. The pointers cross domains as Gray codes through two-flop synchronizers. An active-low master reset empties the buffer. It takes effect as soon as it is driven low and is released separately in each domain, on that domain's own clock.

Top module: `qflag_fifo`

## Requirements
- R1: A word is stored on a rising `wr_clk` edge when `wr_en_n` is 0 and the buffer is not full. A write attempted while full stores nothing: the 1024 stored words come back unchanged, and no extra word follows them.
- R2: On a rising `rd_clk` edge with `rd_en_n` at 0 and the buffer not empty, `rd_data` takes the oldest unread word. Words come back in write order, with none lost. Without an accepted read, `rd_data` keeps its value.
- R3: `ef_n` is 0 when the fill level is 0 (empty, set on `rd_clk`) or 1024 (full, set on `wr_clk`). It is 1 for every other level.
- R4: `qtq_n` is 0 when the fill level is at most 256 (evaluated on `rd_clk`) or at least 768 (evaluated on `wr_clk`). It is 1 for levels 257 to 767.
- R5: `half_n` is 0 when the fill level is greater than 512, and 1 otherwise. It is evaluated on `wr_clk`.
- R6: A write attempted while full drives `fault_n` to 0 from the next `wr_clk` edge. It stays 0 until the buffer is no longer full.
- R7: A read attempted while empty drives `fault_n` to 0 from the next `rd_clk` edge and leaves `rd_data` unchanged. `fault_n` stays 0 until the buffer is no longer empty.
- R8: While `mrst_n` is 0, the buffer is empty without waiting for any clock edge: `ef_n`=0, `qtq_n`=0, `half_n`=1, `fault_n`=1 and `rd_data`=0.
- R9: While `rd_oe_n` is 1, `rd_data` is all zeros. While it is 0, `rd_data` shows the held read word.
- R10: Each pointer changes by exactly one Gray-code bit per step before crossing domains. Data stays in order when both clocks run freely and reads and writes overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low |
| wr_en_n | input | 1 | Write request, active low |
| wr_data | input | 36 | Word to store |
| rd_en_n | input | 1 | Read request, active low |
| rd_oe_n | input | 1 | Output gate, active low |
| rd_data | output | 36 | Last word read, or zero when gated |
| ef_n | output | 1 | Empty-or-full flag, active low |
| qtq_n | output | 1 | Lower/upper quartile flag, active low |
| half_n | output | 1 | More-than-half flag, active low |
| fault_n | output | 1 | Latched underflow/overflow fault, active low |

## Verification
Some results change on the very edge that causes them, because only local registers lie on the path:
- read data after an accepted read edge;
- a fault after an illegal request;
- the empty flag after the last read;
- the full flag after the last write.

The bench samples each of these at the falling edge that follows. The other flags depend on the opposite domain's pointer, which passes through two synchronizing flops and the observing domain's own update. They are due two to three observing-clock cycles later. The bench therefore waits six cycles of each clock after a stimulus before it checks a level flag. The free-running overlap test reads only while the empty-or-full flag is high. It checks each word at the falling edge after its read.

// File: rtl/qff_pkg.sv
package qff_pkg;

  typedef struct packed {
    logic full;
    logic upper;
    logic over_half;
    logic ovf_fault;
  } wr_flags_t;

  typedef struct packed {
    logic empty;
    logic lower;
    logic unf_fault;
  } rd_flags_t;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [31:0] fill_level(input logic [31:0] head,
                                             input logic [31:0] tail);
    return head - tail;
  endfunction

endpackage

// File: rtl/qff_rst_sync.sv
module qff_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage <= 2'b00;
    else         stage <= {stage[0], 1'b1};
  end

  assign srst_n = stage[1];
endmodule

// File: rtl/qff_vsync.sv
module qff_vsync #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/qff_wr_ctl.sv
module qff_wr_ctl
  import qff_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wen_n,
  input  logic [PW-1:0] rgray_s,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] wgray,
  output logic [PW-1:0] wcount,
  output logic          fire,
  output wr_flags_t     flg
);
  localparam logic [PW-1:0] FULL_LVL  = PW'(DEPTH);
  localparam logic [PW-1:0] UPPER_LVL = PW'(DEPTH - DEPTH / 4);
  localparam logic [PW-1:0] HALF_LVL  = PW'(DEPTH / 2);

  logic [PW-1:0] rptr_seen;
  logic [PW-1:0] wptr_nx;
  logic          full;
  logic          ovf_q;

  assign rptr_seen = PW'(gray2bin(32'(rgray_s)));
  assign wcount    = PW'(fill_level(32'(wptr), 32'(rptr_seen)));
  assign full      = (wcount == FULL_LVL);
  assign fire      = !wen_n && !full;
  assign wptr_nx   = wptr + PW'(1);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wptr  <= '0;
      wgray <= '0;
    end else if (fire) begin
      wptr  <= wptr_nx;
      wgray <= PW'(bin2gray(32'(wptr_nx)));
    end
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n)     ovf_q <= 1'b0;
    else if (!full)  ovf_q <= 1'b0;
    else if (!wen_n) ovf_q <= 1'b1;
  end

  always_comb begin
    flg.full      = full;
    flg.upper     = (wcount >= UPPER_LVL);
    flg.over_half = (wcount > HALF_LVL);
    flg.ovf_fault = ovf_q && full;
  end
endmodule

// File: rtl/qff_rd_ctl.sv
module qff_rd_ctl
  import qff_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          ren_n,
  input  logic [PW-1:0] wgray_s,
  output logic [PW-1:0] rptr,
  output logic [PW-1:0] rgray,
  output logic [PW-1:0] rcount,
  output logic          fire,
  output rd_flags_t     flg
);
  localparam logic [PW-1:0] LOWER_LVL = PW'(DEPTH / 4);

  logic [PW-1:0] wptr_seen;
  logic [PW-1:0] rptr_nx;
  logic          empty;
  logic          unf_q;

  assign wptr_seen = PW'(gray2bin(32'(wgray_s)));
  assign rcount    = PW'(fill_level(32'(wptr_seen), 32'(rptr)));
  assign empty     = (rcount == '0);
  assign fire      = !ren_n && !empty;
  assign rptr_nx   = rptr + PW'(1);

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rptr  <= '0;
      rgray <= '0;
    end else if (fire) begin
      rptr  <= rptr_nx;
      rgray <= PW'(bin2gray(32'(rptr_nx)));
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)     unf_q <= 1'b0;
    else if (!empty) unf_q <= 1'b0;
    else if (!ren_n) unf_q <= 1'b1;
  end

  always_comb begin
    flg.empty     = empty;
    flg.lower     = (rcount <= LOWER_LVL);
    flg.unf_fault = unf_q && empty;
  end
endmodule

// File: rtl/qff_ram.sv
module qff_ram #(
  parameter int DEPTH = 1024,
  parameter int DW    = 36,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rq
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  rq <= '0;
    else if (re)  rq <= mem[raddr];
  end
endmodule

// File: rtl/qflag_fifo.sv
module qflag_fifo
  import qff_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 36,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst_n,
  input  logic          wr_en_n,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en_n,
  input  logic          rd_oe_n,
  output logic [DW-1:0] rd_data,
  output logic          ef_n,
  output logic          qtq_n,
  output logic          half_n,
  output logic          fault_n
);
  logic          wrst_n, rrst_n;
  logic [PW-1:0] wptr, wgray, w_count, rgray_s;
  logic [PW-1:0] rptr, rgray, r_count, wgray_s;
  logic          w_fire, r_fire;
  logic [DW-1:0] rq;
  wr_flags_t     wfl;
  rd_flags_t     rfl;
  logic          w_full, w_ovf, r_empty, r_unf;

  qff_rst_sync u_wrst (.clk(wr_clk), .arst_n(mrst_n), .srst_n(wrst_n));
  qff_rst_sync u_rrst (.clk(rd_clk), .arst_n(mrst_n), .srst_n(rrst_n));

  qff_vsync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  qff_vsync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  qff_wr_ctl #(.DEPTH(DEPTH)) u_wctl (
    .wclk(wr_clk), .wrst_n(wrst_n), .wen_n(wr_en_n), .rgray_s(rgray_s),
    .wptr(wptr), .wgray(wgray), .wcount(w_count), .fire(w_fire), .flg(wfl)
  );

  qff_rd_ctl #(.DEPTH(DEPTH)) u_rctl (
    .rclk(rd_clk), .rrst_n(rrst_n), .ren_n(rd_en_n), .wgray_s(wgray_s),
    .rptr(rptr), .rgray(rgray), .rcount(r_count), .fire(r_fire), .flg(rfl)
  );

  qff_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .wclk(wr_clk), .we(w_fire), .waddr(wptr[AW-1:0]), .wdata(wr_data),
    .rclk(rd_clk), .rrst_n(rrst_n), .re(r_fire), .raddr(rptr[AW-1:0]), .rq(rq)
  );

  assign w_full  = wfl.full;
  assign w_ovf   = wfl.ovf_fault;
  assign r_empty = rfl.empty;
  assign r_unf   = rfl.unf_fault;

  assign rd_data = rd_oe_n ? '0 : rq;
  assign ef_n    = !(r_empty || w_full);
  assign qtq_n   = !(rfl.lower || wfl.upper);
  assign half_n  = !wfl.over_half;
  assign fault_n = !(r_unf || w_ovf);
endmodule

// File: rtl/qff_chk.sv
module qff_chk #(
  parameter int DEPTH = 1024,
  parameter int DW    = 36,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input logic          wclk,
  input logic          rclk,
  input logic          wrst_n,
  input logic          rrst_n,
  input logic          wen_n,
  input logic          ren_n,
  input logic          w_fire,
  input logic          r_fire,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rptr,
  input logic [PW-1:0] rgray,
  input logic [PW-1:0] w_count,
  input logic [PW-1:0] r_count,
  input logic          w_full,
  input logic          r_empty,
  input logic          w_ovf,
  input logic          r_unf,
  input logic [DW-1:0] rq
);
  localparam logic [PW-1:0] CAP = PW'(DEPTH);

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
    w_count <= CAP); // R1
  AST_WPTR_STEP: assert property (@(posedge wclk) disable iff (!wrst_n)
    w_fire |=> wptr == $past(wptr) + PW'(1)); // R1
  AST_WPTR_HOLD: assert property (@(posedge wclk) disable iff (!wrst_n)
    !w_fire |=> $stable(wptr)); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rrst_n)
    r_count <= CAP); // R2
  AST_RDATA_HOLD: assert property (@(posedge rclk) disable iff (!rrst_n)
    !r_fire |=> $stable(rq)); // R2
  AST_OVF_LATCH: assert property (@(posedge wclk) disable iff (!wrst_n)
    (w_full && !wen_n) |=> (w_ovf || !w_full)); // R6
  AST_UNF_LATCH: assert property (@(posedge rclk) disable iff (!rrst_n)
    (r_empty && !ren_n) |=> (r_unf || !r_empty)); // R7
  AST_WGRAY_ONE: assert property (@(posedge wclk) disable iff (!wrst_n)
    $onehot0(wgray ^ $past(wgray))); // R10
  AST_RGRAY_ONE: assert property (@(posedge rclk) disable iff (!rrst_n)
    $onehot0(rgray ^ $past(rgray))); // R10
  AST_RPTR_STEP: assert property (@(posedge rclk) disable iff (!rrst_n)
    r_fire |=> rptr == $past(rptr) + PW'(1)); // R2
endmodule

bind qflag_fifo qff_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .wclk(wr_clk), .rclk(rd_clk), .wrst_n(wrst_n), .rrst_n(rrst_n),
  .wen_n(wr_en_n), .ren_n(rd_en_n), .w_fire(w_fire), .r_fire(r_fire),
  .wptr(wptr), .wgray(wgray), .rptr(rptr), .rgray(rgray),
  .w_count(w_count), .r_count(r_count), .w_full(w_full), .r_empty(r_empty),
  .w_ovf(w_ovf), .r_unf(r_unf), .rq(rq)
);

// File: tb/qflag_fifo_tb.sv
module qflag_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RCLK_PERIOD = (CLK_PERIOD * 7) / 5;
  localparam int DW = 36;
  localparam int DEPTH = 1024;

  logic          wr_clk = 0, rd_clk = 0, mrst_n = 0;
  logic          wr_en_n = 1, rd_en_n = 1, rd_oe_n = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          ef_n, qtq_n, half_n, fault_n;

  int total = 0, bad = 0;
  int wr_idx = 0, rd_idx = 0;

  always #(CLK_PERIOD / 2) wr_clk = ~wr_clk;
  always #(RCLK_PERIOD / 2) rd_clk = ~rd_clk;

  qflag_fifo u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n),
    .rd_oe_n(rd_oe_n), .rd_data(rd_data), .ef_n(ef_n), .qtq_n(qtq_n),
    .half_n(half_n), .fault_n(fault_n)
  );

  function automatic logic [DW-1:0] pat(input int k);
    return {4'h9, 16'(k * 37 + 5), 16'(k)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic flags(input string req, input logic e_ef, input logic e_q,
                       input logic e_h, input logic e_f);
    chk(ef_n == e_ef, req, "ef_n", DW'(ef_n), DW'(e_ef));
    chk(qtq_n == e_q, req, "qtq_n", DW'(qtq_n), DW'(e_q));
    chk(half_n == e_h, req, "half_n", DW'(half_n), DW'(e_h));
    chk(fault_n == e_f, req, "fault_n", DW'(fault_n), DW'(e_f));
  endtask

  task automatic settle();
    repeat (6) @(negedge wr_clk);
    repeat (6) @(negedge rd_clk);
  endtask

  task automatic write_words(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge wr_clk);
      wr_en_n = 0;
      wr_data = pat(wr_idx);
      wr_idx++;
    end
    @(negedge wr_clk);
    wr_en_n = 1;
  endtask

  task automatic read_words(input int n, input string req);
    @(negedge rd_clk);
    rd_en_n = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge rd_clk);
      chk(rd_data == pat(rd_idx), req, "read order", rd_data, pat(rd_idx));
      rd_idx++;
      if (k == n - 1) rd_en_n = 1;
    end
  endtask

  task automatic t_reset();
    mrst_n = 0;
    repeat (3) @(negedge wr_clk);
    flags("R8", 1'b0, 1'b0, 1'b1, 1'b1);
    chk(rd_data == '0, "R8", "rd_data in reset", rd_data, '0);
    mrst_n = 1;
    settle();
    flags("R8", 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_order();
    write_words(5);
    settle();
    flags("R3", 1'b1, 1'b0, 1'b1, 1'b1);
    read_words(5, "R2");
    settle();
    chk(ef_n == 1'b0, "R3", "empty after drain", DW'(ef_n), '0);
  endtask

  task automatic t_levels();
    write_words(256);  settle(); flags("R4", 1'b1, 1'b0, 1'b1, 1'b1);
    write_words(1);    settle(); flags("R4", 1'b1, 1'b1, 1'b1, 1'b1);
    write_words(255);  settle(); flags("R5", 1'b1, 1'b1, 1'b1, 1'b1);
    write_words(1);    settle(); flags("R5", 1'b1, 1'b1, 1'b0, 1'b1);
    write_words(254);  settle(); flags("R4", 1'b1, 1'b1, 1'b0, 1'b1);
    write_words(1);    settle(); flags("R4", 1'b1, 1'b0, 1'b0, 1'b1);
    write_words(255);  settle(); flags("R3", 1'b1, 1'b0, 1'b0, 1'b1);
    write_words(1);
    chk(ef_n == 1'b0, "R3", "full flag", DW'(ef_n), '0);
  endtask

  task automatic t_overflow();
    @(negedge wr_clk);
    wr_en_n = 0;
    wr_data = 36'h0_DEAD_BEEF;
    @(negedge wr_clk);
    wr_en_n = 1;
    chk(fault_n == 1'b0, "R6", "overflow fault", DW'(fault_n), '0);
    repeat (3) @(negedge wr_clk);
    chk(fault_n == 1'b0, "R6", "fault latched", DW'(fault_n), '0);
    read_words(1, "R2");
    settle();
    flags("R6", 1'b1, 1'b0, 1'b0, 1'b1);
    write_words(1);
    settle();
    read_words(DEPTH, "R1");
    settle();
    flags("R1", 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_underflow();
    logic [DW-1:0] held;
    held = rd_data;
    @(negedge rd_clk);
    rd_en_n = 0;
    @(negedge rd_clk);
    rd_en_n = 1;
    chk(fault_n == 1'b0, "R7", "underflow fault", DW'(fault_n), '0);
    chk(rd_data == held, "R7", "data held", rd_data, held);
    repeat (3) @(negedge rd_clk);
    chk(fault_n == 1'b0, "R7", "fault latched", DW'(fault_n), '0);
    write_words(1);
    settle();
    flags("R7", 1'b1, 1'b0, 1'b1, 1'b1);
    read_words(1, "R2");
    settle();
  endtask

  task automatic t_gate();
    write_words(1);
    settle();
    read_words(1, "R2");
    rd_oe_n = 1;
    @(negedge rd_clk);
    chk(rd_data == '0, "R9", "gated output", rd_data, '0);
    rd_oe_n = 0;
    @(negedge rd_clk);
    chk(rd_data == pat(rd_idx - 1), "R9", "ungated output", rd_data, pat(rd_idx - 1));
  endtask

  task automatic t_overlap();
    int got;
    got = 0;
    fork
      write_words(300);
      begin
        while (got < 300) begin
          @(negedge rd_clk);
          if (!rd_en_n) begin
            chk(rd_data == pat(rd_idx), "R10", "overlap order", rd_data, pat(rd_idx));
            rd_idx++;
            got++;
          end
          rd_en_n = (got < 300 && ef_n) ? 1'b0 : 1'b1;
        end
        rd_en_n = 1;
      end
    join
    settle();
    flags("R10", 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_midreset();
    write_words(10);
    settle();
    read_words(1, "R2");
    @(negedge wr_clk);
    mrst_n = 0;
    #1;
    chk(rd_data == '0, "R8", "async data clear", rd_data, '0);
    chk(ef_n == 1'b0, "R8", "async empty", DW'(ef_n), '0);
    @(negedge wr_clk);
    mrst_n = 1;
    wr_idx = 0;
    rd_idx = 0;
    settle();
    write_words(3);
    settle();
    read_words(3, "R2");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_order();
    t_levels();
    t_overflow();
    t_underflow();
    t_gate();
    t_overlap();
    t_midreset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule